// File: doc/BRIEF.md
# I2C Transmit Byte Queue Streamer

This block sits between the software data port of an I2C master and its bit-level byte engine. Software first turns on queue mode through the control port. Each data-port write then drops one byte into a 64-entry queue. While the queue holds data and the streamer is not halted, the head byte is offered to the byte engine. When the engine reports that the byte went out with an ACK, the byte is retired and the next one is offered in the following cycle.

A refused byte (NAK) halts the streamer. The refused byte and every byte behind it stay in the queue. Nothing more is offered until software flushes the queue through the control port. Status flags report a drained queue, a refusal and a write that hit a full queue. Each flag is cleared by writing a one to it, and each one can be routed to the interrupt line through its enable bit. START and STOP conditions are not handled here; they belong to the command engine.

Top module: `txq_stream`

## Requirements
- R1: After reset the queue level is 0, `fifo_empty` is 1, `sts` is 0, `nak_flag` is 0, and `byte_req` and `irq` are 0.
- R2: With control bit 6 written as 1, each data-port write stores one byte. Stored bytes reach `byte_data` strictly in write order, and `fifo_level` counts the bytes held.
- R3: After an ACKed `byte_done`, if bytes remain, `byte_req` is high again in the very next cycle, carrying the next byte.
- R4: The ACK of the last held byte sets `sts[1]` (drained) on the same clock edge that brings `fifo_level` to 0 and `fifo_empty` to 1. `irq` is high while any `sts` bit is set together with its `irq_en` bit, with `irq_en[1]` for drained.
- R5: A `byte_done` with `byte_nak` set, while `byte_req` is high, sets `sts[0]` and `nak_flag` on the next edge. `byte_req` then stays low, and the refused byte and all later bytes remain counted in `fifo_level`.
- R6: A control write with bit 7 set empties the queue (level 0) and clears `nak_flag`. Bit 7 is not stored, and the flush does not set `sts[1]`.
- R7: A data-port write while 64 bytes are held is dropped. The level stays 64, `sts[2]` (overflow) is set, and the byte is never offered.
- R8: With control bit 6 written as 0, data-port writes are ignored and `byte_req` stays low.
- R9: `sts` bits clear when written with a 1 through `sts_clr_wr`/`sts_clr_mask`, bit for bit. Bits written with 0 are kept.
- R10: The queue holds exactly 64 bytes, and all 64 bytes of a full queue are streamed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control value: bit 6 queue enable, bit 7 flush |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Byte to queue |
| sts_clr_wr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 3 | Write-one-to-clear mask for `sts` |
| irq_en | input | 3 | Interrupt enable per status bit (bit 1 drained) |
| byte_done | input | 1 | Byte engine finished the offered byte |
| byte_nak | input | 1 | The finished byte was refused |
| byte_req | output | 1 | A byte is offered to the byte engine |
| byte_data | output | 8 | Offered byte (queue head) |
| sts | output | 3 | bit 0 refused, bit 1 drained, bit 2 overflow |
| nak_flag | output | 1 | Streamer halted by a refusal |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_level | output | 7 | Bytes held |
| irq | output | 1 | Interrupt request |

## Verification
All inputs are driven and all outputs sampled on the falling edge. A strobe given at one falling edge takes effect on the next rising edge, so its result is checked at the falling edge that follows. This holds for a stored byte and its level, a flush, the overflow flag, a status clear and the drained flag. After a `byte_done` pulse, the byte engine model checks at the very next falling edge that the next byte is offered after an ACK and that nothing is offered after a NAK. The scoreboard compares every offered byte against the write-order queue at the moment the model completes it.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int CTL_EN_BIT    = 6;
    localparam int CTL_FLUSH_BIT = 7;
    localparam int ST_NAK        = 0;
    localparam int ST_DRAIN      = 1;
    localparam int ST_OVF        = 2;
    localparam int ST_W          = 3;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } store_t;

    store_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push) s_d.wr = bump(s_q.wr);
            if (pop)  s_d.rd = bump(s_q.rd);
            case ({push, pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[s_q.wr] <= wdata;
    end

    assign rdata = mem[s_q.rd];
    assign count = s_q.cnt;
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);

    // R10: level never exceeds the depth
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
    // R6: a flush leaves the queue empty
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R2: nothing is retired from an empty queue
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [7:0]      ctl_wdata,
    input  logic            dat_wr,
    input  logic            sts_clr_wr,
    input  logic [ST_W-1:0] sts_clr_mask,
    input  logic [ST_W-1:0] irq_en,
    input  logic            byte_done,
    input  logic            byte_nak,
    input  logic            q_full,
    input  logic            q_empty,
    input  logic [CW-1:0]   q_count,
    output logic            push,
    output logic            pop,
    output logic            flush,
    output logic            byte_req,
    output logic [ST_W-1:0] sts,
    output logic            nak_flag,
    output logic            irq
);
    typedef struct packed {
        logic            en;
        logic            halted;
        logic [ST_W-1:0] sts;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [ST_W-1:0] set_v;
    logic            refused;
    logic            ctl_unused;

    assign ctl_unused = ^ctl_wdata[5:0];

    assign flush    = ctl_wr && ctl_wdata[CTL_FLUSH_BIT];
    assign byte_req = c_q.en && !c_q.halted && !q_empty;
    assign refused  = byte_req && byte_done && byte_nak;
    assign pop      = byte_req && byte_done && !byte_nak && !flush;
    assign push     = dat_wr && c_q.en && !q_full && !flush;

    always_comb begin
        c_d = c_q;
        set_v = '0;
        set_v[ST_NAK]   = refused;
        set_v[ST_DRAIN] = pop && (q_count == CW'(1)) && !push;
        set_v[ST_OVF]   = dat_wr && c_q.en && q_full && !flush;
        if (ctl_wr) c_d.en = ctl_wdata[CTL_EN_BIT];
        if (flush)        c_d.halted = 1'b0;
        else if (refused) c_d.halted = 1'b1;
        c_d.sts = (c_q.sts & ~(sts_clr_wr ? sts_clr_mask : '0)) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sts      = c_q.sts;
    assign nak_flag = c_q.halted;
    assign irq      = |(c_q.sts & irq_en);

    // R5: a refusal stops the offer and raises the flags
    a_r5_nak_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && byte_done && byte_nak && !ctl_wr) |=> (!byte_req && nak_flag && sts[ST_NAK]));
    // R7: a write into a full queue is recorded as overflow
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && q_full && c_q.en && !ctl_wr) |=> sts[ST_OVF]);
    // R4: retiring the last byte flags drained
    a_r4_drain_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && byte_done && !byte_nak && q_count == CW'(1) && !dat_wr && !ctl_wr) |=> sts[ST_DRAIN]);
    // R8: disabled queue offers nothing
    a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[CTL_EN_BIT]) |=> !byte_req);
endmodule

// File: rtl/txq_stream.sv
module txq_stream
    import txq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic [7:0]                 ctl_wdata,
    input  logic                       dat_wr,
    input  logic [W-1:0]               dat_wdata,
    input  logic                       sts_clr_wr,
    input  logic [2:0]                 sts_clr_mask,
    input  logic [2:0]                 irq_en,
    input  logic                       byte_done,
    input  logic                       byte_nak,
    output logic                       byte_req,
    output logic [W-1:0]               byte_data,
    output logic [2:0]                 sts,
    output logic                       nak_flag,
    output logic                       fifo_empty,
    output logic [$clog2(DEPTH+1)-1:0] fifo_level,
    output logic                       irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop, flush, q_full, q_empty;
    logic [CW-1:0] q_count;

    txq_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .wdata (dat_wdata),
        .rdata (byte_data),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    txq_ctrl #(.CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_wdata    (ctl_wdata),
        .dat_wr       (dat_wr),
        .sts_clr_wr   (sts_clr_wr),
        .sts_clr_mask (sts_clr_mask),
        .irq_en       (irq_en),
        .byte_done    (byte_done),
        .byte_nak     (byte_nak),
        .q_full       (q_full),
        .q_empty      (q_empty),
        .q_count      (q_count),
        .push         (push),
        .pop          (pop),
        .flush        (flush),
        .byte_req     (byte_req),
        .sts          (sts),
        .nak_flag     (nak_flag),
        .irq          (irq)
    );

    assign fifo_empty = q_empty;
    assign fifo_level = q_count;
endmodule

// File: tb/txq_stream_test.sv
module txq_stream_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       sts_clr_wr = 1'b0;
    logic [2:0] sts_clr_mask = '0;
    logic [2:0] irq_en = '0;
    logic       byte_done = 1'b0;
    logic       byte_nak = 1'b0;
    logic       byte_req, nak_flag, fifo_empty, irq;
    logic [7:0] byte_data;
    logic [2:0] sts;
    logic [6:0] fifo_level;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    bit eng_on = 0;
    int nak_at = -1;
    int offered = 0;
    bit want_next = 0;
    bit want_quiet = 0;
    localparam int LAT = 3;

    always #10 clk = ~clk;

    txq_stream uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .sts_clr_wr(sts_clr_wr),
        .sts_clr_mask(sts_clr_mask), .irq_en(irq_en), .byte_done(byte_done),
        .byte_nak(byte_nak), .byte_req(byte_req), .byte_data(byte_data),
        .sts(sts), .nak_flag(nak_flag), .fifo_empty(fifo_empty),
        .fifo_level(fifo_level), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] b, input bit stored);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = b;
        if (stored) exp_q.push_back(b);
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic clr_sts(input logic [2:0] m);
        @(negedge clk); sts_clr_wr = 1'b1; sts_clr_mask = m;
        @(negedge clk); sts_clr_wr = 1'b0;
    endtask

    // byte engine model and scoreboard monitor
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            byte_done = 1'b0; byte_nak = 1'b0;
            if (want_next) begin
                chk(byte_req === 1'b1, "R3 next byte offered", int'(byte_req), 1);
                want_next = 0;
            end
            if (want_quiet) begin
                chk(byte_req === 1'b0, "R5 no offer after refusal", int'(byte_req), 0);
                want_quiet = 0;
            end
            if (eng_on && byte_req) begin
                if (cnt == LAT) begin
                    cnt = 0;
                    if (offered == nak_at) begin
                        byte_done = 1'b1; byte_nak = 1'b1; want_quiet = 1;
                    end else begin
                        if (exp_q.size() == 0) begin
                            chk(0, "R2 unexpected byte offered", int'(byte_data), -1);
                        end else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            chk(byte_data == e, "R2 byte order", int'(byte_data), int'(e));
                        end
                        byte_done = 1'b1;
                        if (exp_q.size() > 0) want_next = 1;
                    end
                    offered++;
                end else begin
                    cnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fifo_level == 0, "R1 level", int'(fifo_level), 0);
        chk(fifo_empty == 1'b1, "R1 empty", int'(fifo_empty), 1);
        chk(sts == 3'b000 && !nak_flag, "R1 status", int'(sts), 0);
        chk(!byte_req && !irq, "R1 req/irq", int'({byte_req, irq}), 0);

        // R8 disabled: writes ignored
        wr_dat(8'h55, 0);
        chk(fifo_level == 0 && !byte_req, "R8 write ignored", int'(fifo_level), 0);

        // R2 enable and fill, then R3/R4 stream out
        ctl_write(8'h40);
        irq_en = 3'b010;
        wr_dat(8'h11, 1); wr_dat(8'h22, 1); wr_dat(8'h33, 1);
        wr_dat(8'h44, 1); wr_dat(8'h5A, 1);
        chk(fifo_level == 5, "R2 level", int'(fifo_level), 5);
        chk(sts[1] == 1'b0, "R4 not drained yet", int'(sts[1]), 0);
        offered = 0; nak_at = -1; eng_on = 1;
        while (!(fifo_empty && exp_q.size() == 0)) @(negedge clk);
        chk(sts[1] == 1'b1, "R4 drained flag", int'(sts[1]), 1);
        chk(irq == 1'b1, "R4 irq", int'(irq), 1);
        @(negedge clk);

        // R9 write-one-to-clear, bit for bit
        clr_sts(3'b101);
        chk(sts[1] == 1'b1, "R9 unmasked bit kept", int'(sts[1]), 1);
        clr_sts(3'b010);
        chk(sts == 3'b000 && !irq, "R9 cleared", int'(sts), 0);

        // R5 refusal on the second byte
        eng_on = 0;
        wr_dat(8'hA0, 1); wr_dat(8'hA1, 1); wr_dat(8'hA2, 1); wr_dat(8'hA3, 1);
        offered = 0; nak_at = 1; eng_on = 1;
        while (!nak_flag) @(negedge clk);
        chk(sts[0] == 1'b1, "R5 nak status", int'(sts[0]), 1);
        repeat (6) @(negedge clk);
        chk(!byte_req, "R5 halted", int'(byte_req), 0);
        chk(fifo_level == 3, "R5 bytes kept", int'(fifo_level), 3);
        chk(!fifo_empty && sts[1] == 1'b0, "R5 not drained", int'(sts[1]), 0);

        // R6 flush
        eng_on = 0;
        ctl_write(8'hC0);
        exp_q.delete();
        chk(fifo_level == 0 && fifo_empty, "R6 flushed", int'(fifo_level), 0);
        chk(!nak_flag, "R6 halt released", int'(nak_flag), 0);
        chk(sts[1] == 1'b0, "R6 flush not drained", int'(sts[1]), 0);
        clr_sts(3'b111);

        // R7/R10 fill to 64, overflow, stream all out
        for (int i = 0; i < 64; i++) wr_dat(8'(i * 7 + 3), 1);
        chk(fifo_level == 64 && sts[2] == 1'b0, "R10 full depth", int'(fifo_level), 64);
        wr_dat(8'hEE, 0);
        chk(fifo_level == 64, "R7 level kept", int'(fifo_level), 64);
        chk(sts[2] == 1'b1, "R7 overflow flag", int'(sts[2]), 1);
        offered = 0; nak_at = -1; eng_on = 1;
        while (!(fifo_empty && exp_q.size() == 0)) @(negedge clk);
        chk(sts[1] == 1'b1, "R10 all 64 streamed", int'(sts[1]), 1);
        repeat (8) @(negedge clk);
        chk(!byte_req, "R7 dropped byte never offered", int'(byte_req), 0);

        // R8 disable again
        ctl_write(8'h00);
        wr_dat(8'h99, 0);
        chk(fifo_level == 0 && !byte_req, "R8 disabled ignores", int'(fifo_level), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule